// File: doc/BRIEF.md
# Round-Robin Warp Issue Pipeline

This block shares one in-order five-stage pipeline (fetch, decode, execute, memory, writeback, one cycle each) among several warps. Every warp has a program counter and a small instruction store held in registers. In each cycle the fetch stage takes at most one instruction, and it picks the warp by rotating round-robin over the warps that may still fetch. Interleaving keeps consecutive instructions of a busy warp apart. A warp that fetches a jump is held back until the jump has left execute and redirected its counter. A warp that fetches its return instruction drops out of the rotation for good.

The execute stage feeds a group of parallel lanes. If a warp has more threads than there are lanes, each instruction stays in execute for several consecutive slices. While it does, fetch, decode and execute hold and a bubble goes on to memory. Software loads the instruction store through a write port and then pulses `start`. The block reports a fetch trace and an issue trace on every cycle, and raises `all_done` once every warp has retired its return.

Top module: `warp_rr_pipe`

## Requirements
- R1: While reset is asserted, and after it, `all_done`, `fetch_valid` and `issue_valid` are 0. An accepted start sets every warp's counter to 0 and the rotation pointer to warp 0, so the first fetch is warp 0 at PC 0.
- R2: `start` is accepted only when the block is idle, meaning never started or `all_done` is high. While warps are running it is ignored. An accepted start clears `all_done` on the next cycle.
- R3: At most one instruction is fetched per cycle. The warp chosen is the first eligible one at or after the warp following the last one fetched, wrapping around.
- R4: Each warp fetches and issues in program order. A non-jump, non-return fetch advances that warp's PC by one.
- R5: An instruction word is {op[1:0], target[PC_W-1:0]}. The op values are 00 arithmetic, 01 jump (always taken, to target), 10 return and 11 arithmetic.
- R6: After a warp fetches a jump it is not fetched again until the jump has left execute. Its next fetch is at the target. With one slice per instruction, that warp's issue following the jump comes 4 cycles after the jump's issue.
- R7: A warp that has fetched its return is never fetched again until the next accepted start.
- R8: Without stalls, an instruction fetched in cycle t is shown on the issue trace in cycle t+3 and is in writeback in cycle t+5.
- R9: With SLICES = ceil(WARP_THREADS/LANES), every instruction is issued in SLICES consecutive cycles with `issue_slice` counting 0 to SLICES-1. No fetch happens in a cycle whose slice is not the last.
- R10: `all_done` rises in the cycle after the last outstanding return is in writeback.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launch pulse for all warps |
| imem_we | input | 1 | Instruction store write enable |
| imem_warp | input | WID_W | Warp whose store is written |
| imem_addr | input | PC_W | Word address in that store |
| imem_data | input | 2+PC_W | Instruction word {op, target} |
| fetch_valid | output | 1 | An instruction is fetched this cycle |
| fetch_warp | output | WID_W | Warp being fetched |
| fetch_pc | output | PC_W | PC being fetched |
| issue_valid | output | 1 | Execute stage drives the lanes this cycle |
| issue_warp | output | WID_W | Warp in execute |
| issue_pc | output | PC_W | PC of the instruction in execute |
| issue_op | output | 2 | Op of the instruction in execute |
| issue_slice | output | SLICE_W | Lane slice being dispatched |
| all_done | output | 1 | Every warp has retired its return |

## Verification
The first pattern is a two-warp program in which warp 0 jumps over a word and warp 1 returns early. On a single-slice instance this separates correct rotation, skipping of retired and jump-blocked warps, the target redirect and the stage latency from an off-by-one in any of them. The same program on an eight-thread, four-lane instance shows whether slices repeat one instruction and stall fetch rather than advancing the pipeline. A start pulse in mid-run and a second launch after completion distinguish an idle-only start from one that restarts blindly, and confirm that a new launch resets the pointer and the counters.

// File: rtl/wrp_pkg.sv
package wrp_pkg;
  typedef enum logic [1:0] {
    OP_ALU = 2'b00,
    OP_JMP = 2'b01,
    OP_RET = 2'b10,
    OP_ALT = 2'b11
  } op_e;

  function automatic int unsigned ceil_div(int unsigned a, int unsigned b);
    return (a + b - 1) / b;
  endfunction

  function automatic int unsigned width_of(int unsigned n);
    return (n <= 2) ? 1 : $clog2(n);
  endfunction

  function automatic int unsigned rr_wrap(int unsigned idx, int unsigned n);
    return idx % n;
  endfunction

  function automatic logic advances_pc(op_e op);
    return (op != OP_JMP) && (op != OP_RET);
  endfunction
endpackage

// File: rtl/wrp_warp_ctx.sv
module wrp_warp_ctx
  import wrp_pkg::*;
#(
  parameter int PC_W = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            launch,
  input  logic            fetch_hit,
  input  op_e             fetch_op,
  input  logic            jmp_resolve,
  input  logic [PC_W-1:0] jmp_tgt,
  input  logic            ret_wb,
  output logic [PC_W-1:0] pc,
  output logic            eligible,
  output logic            retired
);
  logic active, jmp_pend, ret_seen;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc <= '0; active <= 1'b0; jmp_pend <= 1'b0; ret_seen <= 1'b0; retired <= 1'b0;
    end else if (launch) begin
      pc <= '0; active <= 1'b1; jmp_pend <= 1'b0; ret_seen <= 1'b0; retired <= 1'b0;
    end else begin
      if (fetch_hit) begin
        if (fetch_op == OP_JMP)      jmp_pend <= 1'b1;
        else if (fetch_op == OP_RET) ret_seen <= 1'b1;
        else                         pc <= pc + 1'b1;
      end
      if (jmp_resolve) begin
        pc       <= jmp_tgt;
        jmp_pend <= 1'b0;
      end
      if (ret_wb) retired <= 1'b1;
    end
  end

  assign eligible = active && !jmp_pend && !ret_seen;

  p_pc_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_hit && !launch && advances_pc(fetch_op)) |=> pc == $past(pc) + 1'b1);
  p_no_fetch_after_ret_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_seen && !launch) |-> !fetch_hit);
  p_retire_needs_ret_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ret_wb |-> ret_seen);
endmodule

// File: rtl/wrp_rr_pick.sv
module wrp_rr_pick
  import wrp_pkg::*;
#(
  parameter int N = 2,
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         launch,
  input  logic         en,
  input  logic [N-1:0] elig,
  output logic         valid,
  output logic [W-1:0] pick
);
  logic [W-1:0] ptr;
  logic         found;

  always_comb begin
    found = 1'b0;
    pick  = '0;
    for (int k = 0; k < N; k++) begin
      if (!found && elig[W'(rr_wrap(int'(ptr) + k, N))]) begin
        found = 1'b1;
        pick  = W'(rr_wrap(int'(ptr) + k, N));
      end
    end
  end

  assign valid = found && en;

  always_ff @(posedge clk) begin
    if (!rst_n || launch) ptr <= '0;
    else if (valid)       ptr <= W'(rr_wrap(int'(pick) + 1, N));
  end

  p_pick_eligible_r3: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> elig[pick]);
endmodule

// File: rtl/wrp_ex_seq.sv
module wrp_ex_seq #(
  parameter int SLICES  = 1,
  parameter int SLICE_W = 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ex_valid,
  output logic [SLICE_W-1:0] slice,
  output logic               last
);
  generate
    if (SLICES == 1) begin : g_single
      assign slice = '0;
      assign last  = 1'b1;
    end else begin : g_multi
      logic [SLICE_W-1:0] cnt;
      always_ff @(posedge clk) begin
        if (!rst_n)                cnt <= '0;
        else if (ex_valid && !last) cnt <= cnt + 1'b1;
        else                       cnt <= '0;
      end
      assign slice = cnt;
      assign last  = (cnt == SLICE_W'(SLICES - 1));
    end
  endgenerate
endmodule

// File: rtl/warp_rr_pipe.sv
module warp_rr_pipe
  import wrp_pkg::*;
#(
  parameter int NUM_WARPS    = 2,
  parameter int WARP_THREADS = 4,
  parameter int LANES        = 4,
  parameter int PROG_DEPTH   = 8,
  localparam int WID_W   = width_of(NUM_WARPS),
  localparam int PC_W    = width_of(PROG_DEPTH),
  localparam int SLICES  = ceil_div(WARP_THREADS, LANES),
  localparam int SLICE_W = width_of(SLICES),
  localparam int INSTR_W = 2 + PC_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic               imem_we,
  input  logic [WID_W-1:0]   imem_warp,
  input  logic [PC_W-1:0]    imem_addr,
  input  logic [INSTR_W-1:0] imem_data,
  output logic               fetch_valid,
  output logic [WID_W-1:0]   fetch_warp,
  output logic [PC_W-1:0]    fetch_pc,
  output logic               issue_valid,
  output logic [WID_W-1:0]   issue_warp,
  output logic [PC_W-1:0]    issue_pc,
  output logic [1:0]         issue_op,
  output logic [SLICE_W-1:0] issue_slice,
  output logic               all_done
);
  localparam int MEM_N = 1 << (WID_W + PC_W);

  typedef struct packed {
    logic             v;
    logic [WID_W-1:0] w;
    logic [PC_W-1:0]  pc;
    op_e              op;
    logic [PC_W-1:0]  tgt;
  } front_t;

  typedef struct packed {
    logic             v;
    logic [WID_W-1:0] w;
    op_e              op;
  } tail_t;

  logic [INSTR_W-1:0] imem [MEM_N];
  front_t fe_r, de_r, ex_r, fe_in;
  tail_t  mem_r, wb_r;

  logic [PC_W-1:0]    pc_v [NUM_WARPS];
  logic [NUM_WARPS-1:0] elig, retired;
  logic launched, launch, stall, ex_last, pick_valid;
  logic [WID_W-1:0] pick;
  logic [INSTR_W-1:0] fword;

  always_ff @(posedge clk) begin
    if (imem_we) imem[{imem_warp, imem_addr}] <= imem_data;
  end

  assign all_done = launched && (&retired);
  assign launch   = start && (!launched || all_done);
  assign stall    = ex_r.v && !ex_last;

  always_ff @(posedge clk) begin
    if (!rst_n)      launched <= 1'b0;
    else if (launch) launched <= 1'b1;
  end

  generate
    for (genvar g = 0; g < NUM_WARPS; g++) begin : g_warp
      wrp_warp_ctx #(.PC_W(PC_W)) u_ctx (
        .clk        (clk),
        .rst_n      (rst_n),
        .launch     (launch),
        .fetch_hit  (fetch_valid && fetch_warp == WID_W'(g)),
        .fetch_op   (fe_in.op),
        .jmp_resolve(ex_r.v && ex_last && ex_r.op == OP_JMP && ex_r.w == WID_W'(g)),
        .jmp_tgt    (ex_r.tgt),
        .ret_wb     (wb_r.v && wb_r.op == OP_RET && wb_r.w == WID_W'(g)),
        .pc         (pc_v[g]),
        .eligible   (elig[g]),
        .retired    (retired[g])
      );
    end
  endgenerate

  wrp_rr_pick #(.N(NUM_WARPS), .W(WID_W)) u_pick (
    .clk   (clk),
    .rst_n (rst_n),
    .launch(launch),
    .en    (!stall),
    .elig  (elig),
    .valid (pick_valid),
    .pick  (pick)
  );

  wrp_ex_seq #(.SLICES(SLICES), .SLICE_W(SLICE_W)) u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .ex_valid(ex_r.v),
    .slice   (issue_slice),
    .last    (ex_last)
  );

  assign fword = imem[{pick, pc_v[pick]}];

  always_comb begin
    fe_in.v   = pick_valid;
    fe_in.w   = pick;
    fe_in.pc  = pc_v[pick];
    fe_in.op  = op_e'(fword[INSTR_W-1 -: 2]);
    fe_in.tgt = fword[PC_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fe_r <= '0; de_r <= '0; ex_r <= '0; mem_r <= '0; wb_r <= '0;
    end else begin
      if (!stall) begin
        fe_r  <= fe_in;
        de_r  <= fe_r;
        ex_r  <= de_r;
        mem_r <= '{v: ex_r.v, w: ex_r.w, op: ex_r.op};
      end else begin
        mem_r <= '0;
      end
      wb_r <= mem_r;
    end
  end

  assign fetch_valid = pick_valid;
  assign fetch_warp  = pick;
  assign fetch_pc    = pc_v[pick];
  assign issue_valid = ex_r.v;
  assign issue_warp  = ex_r.w;
  assign issue_pc    = ex_r.pc;
  assign issue_op    = ex_r.op;

  p_stall_blocks_fetch_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_valid && !ex_last) |-> !fetch_valid);
  p_slice_walk_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_valid && !ex_last) |=> issue_valid && issue_warp == $past(issue_warp)
      && issue_slice == $past(issue_slice) + 1'b1);
  p_jmp_spacing_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_valid |-> !((fe_r.v && fe_r.w == fetch_warp && fe_r.op == OP_JMP) ||
                      (de_r.v && de_r.w == fetch_warp && de_r.op == OP_JMP) ||
                      (ex_r.v && ex_r.w == fetch_warp && ex_r.op == OP_JMP)));
  p_done_after_wb_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(all_done) |-> $past(wb_r.v && wb_r.op == OP_RET));
  p_idle_outputs_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !launched |-> !fetch_valid && !issue_valid && !all_done);
endmodule

// File: tb/warp_rr_pipe_bench.sv
module warp_rr_pipe_bench;
  localparam int PC_W = 3;

  // Program writes {warp, addr, data}; op in data[4:3], target in data[2:0] (R5)
  localparam logic [15:0] PROG [7] = '{
    16'h0_0_00, 16'h0_1_0B, 16'h0_2_00, 16'h0_3_18, 16'h0_4_10,
    16'h1_0_00, 16'h1_1_10
  };
  // Expected order of fetch/issue: {warp, pc}
  localparam logic [7:0] EXP [6] = '{8'h00, 8'h10, 8'h01, 8'h11, 8'h03, 8'h04};

  logic clk = 1'b0, rst_n = 1'b0, start_a = 1'b0, start_b = 1'b0;
  logic imem_we = 1'b0;
  logic [0:0] imem_warp = '0;
  logic [PC_W-1:0] imem_addr = '0;
  logic [PC_W+1:0] imem_data = '0;

  logic fv_a, iv_a, ad_a, fv_b, iv_b, ad_b;
  logic [0:0] fw_a, iw_a, fw_b, iw_b;
  logic [PC_W-1:0] fp_a, ip_a, fp_b, ip_b;
  logic [1:0] io_a, io_b;
  logic [0:0] is_a, is_b;

  always #5 clk = ~clk;

  warp_rr_pipe u_warp_rr_pipe (
    .clk(clk), .rst_n(rst_n), .start(start_a), .imem_we(imem_we),
    .imem_warp(imem_warp), .imem_addr(imem_addr), .imem_data(imem_data),
    .fetch_valid(fv_a), .fetch_warp(fw_a), .fetch_pc(fp_a),
    .issue_valid(iv_a), .issue_warp(iw_a), .issue_pc(ip_a), .issue_op(io_a),
    .issue_slice(is_a), .all_done(ad_a));

  warp_rr_pipe #(.WARP_THREADS(8)) u_warp_rr_pipe_w8 (
    .clk(clk), .rst_n(rst_n), .start(start_b), .imem_we(imem_we),
    .imem_warp(imem_warp), .imem_addr(imem_addr), .imem_data(imem_data),
    .fetch_valid(fv_b), .fetch_warp(fw_b), .fetch_pc(fp_b),
    .issue_valid(iv_b), .issue_warp(iw_b), .issue_pc(ip_b), .issue_op(io_b),
    .issue_slice(is_b), .all_done(ad_b));

  int nchk = 0, nfail = 0, cyc = 0;
  int fa_w[64], fa_p[64], fa_c[64], ia_w[64], ia_p[64], ia_c[64];
  int ib_w[64], ib_p[64], ib_s[64];
  int nfa = 0, nia = 0, nib = 0, stall_bad = 0, done_c = -1;

  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (fv_a && nfa < 64) begin
      fa_w[nfa] <= int'(fw_a); fa_p[nfa] <= int'(fp_a); fa_c[nfa] <= cyc; nfa <= nfa + 1;
    end
    if (iv_a && nia < 64) begin
      ia_w[nia] <= int'(iw_a); ia_p[nia] <= int'(ip_a); ia_c[nia] <= cyc; nia <= nia + 1;
    end
    if (iv_b && nib < 64) begin
      ib_w[nib] <= int'(iw_b); ib_p[nib] <= int'(ip_b); ib_s[nib] <= int'(is_b); nib <= nib + 1;
    end
    if (iv_b && is_b == 1'b0 && fv_b) stall_bad <= stall_bad + 1;
    if (ad_a && done_c < 0) done_c <= cyc;
  end

  task automatic chk(string req, int act, int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  endtask

  task automatic wait_done_a(string req);
    int n = 0;
    while (!ad_a && n < 300) begin @(negedge clk); n++; end
    chk(req, int'(ad_a), 1);
  endtask

  initial begin
    #(100000 * 10);
    nchk++; nfail++;
    $display("FAIL watchdog: actual running expected finished");
    finish_run();
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    // R1: idle outputs during reset
    chk("R1 all_done in reset", int'(ad_a | ad_b), 0);
    chk("R1 fetch_valid in reset", int'(fv_a | fv_b), 0);
    chk("R1 issue_valid in reset", int'(iv_a | iv_b), 0);
    rst_n = 1'b1;
    foreach (PROG[i]) begin
      imem_we = 1'b1; imem_warp = PROG[i][12]; imem_addr = PROG[i][10:8];
      imem_data = PROG[i][PC_W+1:0];
      @(negedge clk);
    end
    imem_we = 1'b0;
    @(negedge clk);
    chk("R1 idle after reset", int'(fv_a | iv_a | ad_a), 0);

    start_a = 1'b1; start_b = 1'b1;
    @(negedge clk);
    start_a = 1'b0; start_b = 1'b0;
    repeat (3) @(negedge clk);
    start_a = 1'b1;                       // R2: pulse while running, must be ignored
    @(negedge clk);
    start_a = 1'b0;
    wait_done_a("R10 run completes");
    n = 0;
    while (!ad_b && n < 300) begin @(negedge clk); n++; end
    chk("R9 wide run completes", int'(ad_b), 1);
    @(negedge clk);

    // Main table walk: fetch order, issue order, wide slices (R1 R3 R4 R5 R6 R7 R9)
    for (int i = 0; i < 6; i++) begin
      chk("R3 fetch warp order", fa_w[i], int'(EXP[i][7:4]));
      chk("R4 fetch pc order", fa_p[i], int'(EXP[i][3:0]));
      chk("R4 issue warp order", ia_w[i], int'(EXP[i][7:4]));
      chk("R5 issue pc order", ia_p[i], int'(EXP[i][3:0]));
      for (int s = 0; s < 2; s++) begin
        chk("R9 wide issue warp", ib_w[2*i+s], int'(EXP[i][7:4]));
        chk("R9 wide issue pc", ib_p[2*i+s], int'(EXP[i][3:0]));
        chk("R9 wide slice", ib_s[2*i+s], s);
      end
    end
    chk("R2 no restart from mid-run start", nfa, 6);
    chk("R9 wide issue count", nib, 12);
    chk("R9 no fetch in non-last slice", stall_bad, 0);
    chk("R8 fetch to issue latency", ia_c[0] - fa_c[0], 3);
    chk("R6 jump issue gap", ia_c[4] - ia_c[2], 4);
    chk("R10 done after last return", done_c - fa_c[5], 6);
    n = 0;
    for (int i = 0; i < 6; i++) if (fa_w[i] == 1) n++;
    chk("R7 retired warp skipped", n, 2);

    // Restart after completion
    start_a = 1'b1;
    @(negedge clk);
    start_a = 1'b0;
    chk("R2 start clears all_done", int'(ad_a), 0);
    wait_done_a("R2 second run completes");
    @(negedge clk);
    chk("R1 restart first warp", fa_w[6], 0);
    chk("R1 restart first pc", fa_p[6], 0);
    chk("R2 second run fetch count", nfa, 12);
    finish_run();
  end
endmodule